// File: doc/BRIEF.md
# Lockable Register Write-Protection Controller

This block guards two groups of configuration registers against stray writes. A 16-bit protection register holds two independent two-bit controls. One covers the pin-mux and GPIO configuration group. The other covers the peripheral clock group: clock enable, stop-disable and clock rate. All registers sit on one simple register bus with an address, a write strobe, write data and combinational read data.

While a control is on, writes to its group are dropped. The target register keeps its value and a one-cycle violation pulse is raised. Each control can lock itself, either on or off. After that, software writes cannot change it and only a reset can. The block is meant to sit between a processor bus and safety-relevant settings. A runaway program then cannot undo the protection before a watchdog reset arrives.

The guarded registers are plain storage with readback. Their real mux and clock functions sit elsewhere.

Top module: `wguard_top`

## Requirements
- R1: After reset the protection register, every guarded register and `prot_viol` all read 0.
- R2: In the protection register, bits 1:0 are the mux/GPIO control and bits 3:2 are the clock control. Bits 15:4 always read 0, even after a write of ones.
- R3: Each control is coded as follows: 00 is off, 01 is on, 10 is off and locked, 11 is on and locked. While bit 1 of a control is 0, a write can set it to any of the four codes.
- R4: While bit 1 of a control is 1, writes leave that control unchanged.
- R5: The two controls update independently. A single write can change an unlocked control while the other control stays locked.
- R6: While the mux/GPIO control reads 01 or 11, writes to the mux/GPIO group (addresses 0x08 to 0x0B) are dropped. The clock group is not affected.
- R7: While the clock control reads 01 or 11, writes to the clock group are dropped. The group is clock enable at 0x10, stop-disable at 0x11 and rate at 0x12.
- R8: A dropped write drives `prot_viol` high for exactly the one cycle after the write's clock edge. Allowed writes and writes to unmapped addresses never raise it.
- R9: Reads are never blocked. `bus_rdata` shows the addressed register combinationally and shows 0 for unmapped addresses.
- R10: A new protection value applies from the next cycle. A guarded write in the cycle right after a protection write is judged by the new value.
- R11: A reset clears locked controls back to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| prot_viol | output | 1 | One-cycle pulse after a dropped write |

## Verification
The hardest case to reach is a mixed state: one control locked while the other is still free. A single write must then alter only the free field. The stimulus table gets there in steps. It locks the mux control in the off state, then writes a value that tries to change both fields. It then locks the clock control on and tries to clear everything. Back-to-back protection and guarded writes with no idle cycle between them exercise the next-cycle rule. A mid-run reset on locked controls shows that only reset releases them.

// File: rtl/wguard_pkg.sv
package wguard_pkg;

   typedef enum logic [1:0] {
      PC_OFF    = 2'b00,
      PC_ON     = 2'b01,
      PC_OFF_LK = 2'b10,
      PC_ON_LK  = 2'b11
   } prot_code_e;

   localparam int MUX_LSB = 0;
   localparam int CLK_LSB = 2;
   localparam int CTRL_W  = 2;
   localparam int USED_W  = 4;

   function automatic logic code_active(input logic [1:0] c);
      return c[0];
   endfunction

   function automatic logic code_locked(input logic [1:0] c);
      return c[1];
   endfunction

endpackage

// File: rtl/wguard_field.sv
module wguard_field
   import wguard_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [1:0] wval,
   output logic [1:0] code,
   output logic       active
);

   prot_code_e state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PC_OFF;
      end else if (wr && !code_locked(state_q)) begin
         state_q <= prot_code_e'(wval);
      end
   end

   assign code   = state_q;
   assign active = code_active(state_q);

endmodule

// File: rtl/wguard_bank.sv
module wguard_bank #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int REG_W  = 16,
   parameter int N_REGS = 4,
   parameter int BASE   = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    wr,
   input  logic [DATA_W-1:0]       wdata,
   input  logic                    guard,
   output logic                    hit,
   output logic                    blocked,
   output logic [DATA_W-1:0]       rd,
   output logic [N_REGS*REG_W-1:0] flat
);

   localparam int FLAT_W = N_REGS * REG_W;

   if (REG_W < 1 || REG_W > DATA_W) begin : g_bad_w
      $error("wguard_bank: REG_W must be in 1..DATA_W");
   end
   if (N_REGS < 1) begin : g_bad_n
      $error("wguard_bank: N_REGS must be at least 1");
   end

   logic [N_REGS-1:0] sel;
   logic [REG_W-1:0]  rd_narrow;
   logic [REG_W-1:0]  store [N_REGS];

   for (genvar i = 0; i < N_REGS; i++) begin : g_reg
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE + i);
      assign sel[i] = (addr == MY_ADDR);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            store[i] <= '0;
         end else if (wr && sel[i] && !guard) begin
            store[i] <= wdata[REG_W-1:0];
         end
      end

      assign flat[i*REG_W +: REG_W] = store[i];
   end

   assign hit     = |sel;
   assign blocked = wr && hit && guard;

   always_comb begin
      rd_narrow = '0;
      for (int k = 0; k < N_REGS; k++) begin
         if (sel[k]) begin
            rd_narrow = rd_narrow | flat[k*REG_W +: REG_W];
         end
      end
   end

   if (REG_W == DATA_W) begin : g_full
      assign rd = rd_narrow;
   end else begin : g_pad
      assign rd = {{(DATA_W-REG_W){1'b0}}, rd_narrow};
   end

   if (FLAT_W > 4096) begin : g_too_big
      $error("wguard_bank: storage too large");
   end

endmodule

// File: rtl/wguard_top.sv
module wguard_top
   import wguard_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 16,
   parameter int REG_W     = 16,
   parameter int MUX_REGS  = 4,
   parameter int CLK_REGS  = 3,
   parameter int PROT_ADDR = 0,
   parameter int MUX_BASE  = 8,
   parameter int CLK_BASE  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              prot_viol
);

   localparam int MUX_END = MUX_BASE + MUX_REGS;
   localparam int CLK_END = CLK_BASE + CLK_REGS;
   localparam logic [ADDR_W-1:0] PROT_A = ADDR_W'(PROT_ADDR);

   if (DATA_W < USED_W) begin : g_bad_dw
      $error("wguard_top: DATA_W too small for protection fields");
   end
   if (MUX_END > (1 << ADDR_W) || CLK_END > (1 << ADDR_W)) begin : g_bad_aw
      $error("wguard_top: register groups exceed address space");
   end
   if (!(MUX_END <= CLK_BASE || CLK_END <= MUX_BASE)) begin : g_overlap
      $error("wguard_top: register groups overlap");
   end
   if ((PROT_ADDR >= MUX_BASE && PROT_ADDR < MUX_END) ||
       (PROT_ADDR >= CLK_BASE && PROT_ADDR < CLK_END)) begin : g_prot_clash
      $error("wguard_top: protection address inside a group");
   end

   logic                     prot_sel;
   logic                     prot_wr;
   logic [1:0]               mux_code;
   logic [1:0]               clk_code;
   logic                     mux_on;
   logic                     clk_on;
   logic [USED_W-1:0]        prot_code;
   logic                     mux_hit;
   logic                     clk_hit;
   logic                     mux_blk;
   logic                     clk_blk;
   logic [DATA_W-1:0]        mux_rd;
   logic [DATA_W-1:0]        clk_rd;
   logic [MUX_REGS*REG_W-1:0] mux_flat;
   logic [CLK_REGS*REG_W-1:0] clk_flat;

   assign prot_sel = (bus_addr == PROT_A);
   assign prot_wr  = bus_wr && prot_sel;

   wguard_field u_mux_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (prot_wr),
      .wval   (bus_wdata[MUX_LSB +: CTRL_W]),
      .code   (mux_code),
      .active (mux_on)
   );

   wguard_field u_clk_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (prot_wr),
      .wval   (bus_wdata[CLK_LSB +: CTRL_W]),
      .code   (clk_code),
      .active (clk_on)
   );

   assign prot_code = {clk_code, mux_code};

   wguard_bank #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .REG_W  (REG_W),
      .N_REGS (MUX_REGS),
      .BASE   (MUX_BASE)
   ) u_mux_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (bus_addr),
      .wr      (bus_wr),
      .wdata   (bus_wdata),
      .guard   (mux_on),
      .hit     (mux_hit),
      .blocked (mux_blk),
      .rd      (mux_rd),
      .flat    (mux_flat)
   );

   wguard_bank #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .REG_W  (REG_W),
      .N_REGS (CLK_REGS),
      .BASE   (CLK_BASE)
   ) u_clk_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (bus_addr),
      .wr      (bus_wr),
      .wdata   (bus_wdata),
      .guard   (clk_on),
      .hit     (clk_hit),
      .blocked (clk_blk),
      .rd      (clk_rd),
      .flat    (clk_flat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot_viol <= 1'b0;
      end else begin
         prot_viol <= mux_blk || clk_blk;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (prot_sel) begin
         bus_rdata[USED_W-1:0] = prot_code;
      end else if (mux_hit) begin
         bus_rdata = mux_rd;
      end else if (clk_hit) begin
         bus_rdata = clk_rd;
      end
   end

endmodule

// File: rtl/wguard_chk.sv
module wguard_chk #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 16,
   parameter int MUX_BITS  = 64,
   parameter int CLK_BITS  = 48,
   parameter int PROT_ADDR = 0
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_wr,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic                prot_viol,
   input logic [3:0]          prot_code,
   input logic                mux_hit,
   input logic                clk_hit,
   input logic [MUX_BITS-1:0] mux_flat,
   input logic [CLK_BITS-1:0] clk_flat
);

   // R2
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(PROT_ADDR)) |-> (bus_rdata[DATA_W-1:4] == '0));

   // R4
   mux_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prot_code[1] |=> (prot_code[1:0] == $past(prot_code[1:0])));

   // R4
   clk_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prot_code[3] |=> (prot_code[3:2] == $past(prot_code[3:2])));

   // R6
   mux_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && mux_hit && prot_code[0]) |=> $stable(mux_flat));

   // R7
   clk_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && clk_hit && prot_code[2]) |=> $stable(clk_flat));

   // R8
   viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prot_viol) |-> $past(bus_wr && (mux_hit || clk_hit)));

   // R8
   viol_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && ((mux_hit && prot_code[0]) || (clk_hit && prot_code[2])))
      |=> prot_viol);

endmodule

bind wguard_top wguard_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .MUX_BITS  (MUX_REGS*REG_W),
   .CLK_BITS  (CLK_REGS*REG_W),
   .PROT_ADDR (PROT_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rdata (bus_rdata),
   .prot_viol (prot_viol),
   .prot_code (prot_code),
   .mux_hit   (mux_hit),
   .clk_hit   (clk_hit),
   .mux_flat  (mux_flat),
   .clk_flat  (clk_flat)
);

// File: tb/tb_wguard_top.sv
module tb_wguard_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        prot_viol;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   wguard_top dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .prot_viol (prot_viol)
   );

   // {req(4), wr(1), addr(8), wdata(16), rd_addr(8), exp_rd(16), exp_viol(1)}
   localparam int NV = 17;
   localparam logic [53:0] VEC [NV] = '{
      {4'd6,  1'b1, 8'h08, 16'h1234, 8'h08, 16'h1234, 1'b0}, // R6 allowed mux write
      {4'd2,  1'b1, 8'h00, 16'hFFF1, 8'h00, 16'h0001, 1'b0}, // R2 reserved read 0
      {4'd6,  1'b1, 8'h08, 16'hAAAA, 8'h08, 16'h1234, 1'b1}, // R6 blocked
      {4'd6,  1'b1, 8'h10, 16'h00FF, 8'h10, 16'h00FF, 1'b0}, // R6 clock group free
      {4'd3,  1'b1, 8'h00, 16'h0000, 8'h00, 16'h0000, 1'b0}, // R3 turn off
      {4'd3,  1'b1, 8'h09, 16'h5555, 8'h09, 16'h5555, 1'b0}, // R3 mux open again
      {4'd3,  1'b1, 8'h00, 16'h0004, 8'h00, 16'h0004, 1'b0}, // R3 clk on
      {4'd7,  1'b1, 8'h12, 16'h0003, 8'h12, 16'h0000, 1'b1}, // R7 rate blocked
      {4'd7,  1'b1, 8'h11, 16'h0007, 8'h11, 16'h0000, 1'b1}, // R7 stop-disable blocked
      {4'd3,  1'b1, 8'h00, 16'h0006, 8'h00, 16'h0006, 1'b0}, // R3 mux off-locked
      {4'd5,  1'b1, 8'h00, 16'h0001, 8'h00, 16'h0002, 1'b0}, // R5 only clk changes
      {4'd5,  1'b1, 8'h0A, 16'h0BAD, 8'h0A, 16'h0BAD, 1'b0}, // R5 off-locked allows
      {4'd5,  1'b1, 8'h00, 16'h000D, 8'h00, 16'h000E, 1'b0}, // R5 clk locks on
      {4'd4,  1'b1, 8'h00, 16'h0000, 8'h00, 16'h000E, 1'b0}, // R4 both locked
      {4'd7,  1'b1, 8'h10, 16'hFFFF, 8'h10, 16'h00FF, 1'b1}, // R7 enable blocked
      {4'd9,  1'b0, 8'h09, 16'hFFFF, 8'h09, 16'h5555, 1'b0}, // R9 read path
      {4'd8,  1'b1, 8'h30, 16'hFFFF, 8'h30, 16'h0000, 1'b0}  // R8 unmapped no pulse
   };

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
      bus_wr   = 1'b0;
      bus_addr = a;
      #1;
      check(req, "read", bus_rdata, exp);
   endtask

   task automatic wr_op(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_wr    = 1'b1;
      bus_addr  = a;
      bus_wdata = d;
   endtask

   initial begin
      #4000000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      string tag;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "viol", {15'd0, prot_viol}, 16'h0);
      rd_chk("R1", 8'h00, 16'h0000);
      rd_chk("R1", 8'h08, 16'h0000);
      rd_chk("R1", 8'h12, 16'h0000);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [53:0] v;
         v   = VEC[i];
         tag = $sformatf("R%0d", v[53:50]);
         @(negedge clk);
         bus_wr    = v[49];
         bus_addr  = v[48:41];
         bus_wdata = v[40:25];
         @(negedge clk);
         bus_wr = 1'b0;
         check(tag, "viol", {15'd0, prot_viol}, {15'd0, v[0]});
         rd_chk(tag, v[24:17], v[16:1]);
      end

      // R11 reset releases locks and clears storage
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      rd_chk("R11", 8'h00, 16'h0000);
      rd_chk("R1", 8'h10, 16'h0000);
      rd_chk("R1", 8'h0A, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;

      // R4 lock on, later writes ignored
      wr_op(8'h00, 16'h0003);
      @(negedge clk);
      rd_chk("R4", 8'h00, 16'h0003);
      wr_op(8'h00, 16'h0001);
      @(negedge clk);
      rd_chk("R4", 8'h00, 16'h0003);

      // R8 single-cycle pulse
      wr_op(8'h0B, 16'h1111);
      @(negedge clk);
      bus_wr = 1'b0;
      check("R8", "viol first", {15'd0, prot_viol}, 16'h1);
      @(negedge clk);
      check("R8", "viol second", {15'd0, prot_viol}, 16'h0);
      rd_chk("R6", 8'h0B, 16'h0000);

      // R10 back-to-back: protection write then guarded write
      wr_op(8'h00, 16'h0004);
      wr_op(8'h10, 16'h00AA);
      @(negedge clk);
      bus_wr = 1'b0;
      check("R10", "viol", {15'd0, prot_viol}, 16'h1);
      rd_chk("R10", 8'h10, 16'h0000);
      rd_chk("R10", 8'h00, 16'h0007);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule